// File: doc/BRIEF.md
# Sequencer Interrupt Status and Clear Unit

This unit holds the interrupt flags of an analog converter that has four sample sequencers and a digital comparator. Each sequencer pulses an end-of-step input when a step finishes converting. That pulse comes with the interrupt-enable bit of the finished step, and only a qualified pulse sets the sequencer's raw flag. A separate comparator event input sets a single sticky comparator flag.

Software sees three registers through a small register port. The first is the raw flags. The second is a mask that gates the raw flags and routes the comparator flag to interrupt lines. The third is a masked status view that is cleared by writing ones. One interrupt line per sequencer carries its own masked flag, plus the comparator flag if the comparator is routed to that line.

A raw flag sets even when its mask bit is 0. Software can therefore poll for completion without taking interrupts.

Top module: `adc_irq_status`

## Requirements
- R1: After reset, every register reads 0 and every interrupt line is low.
- R2: One cycle after `step_done_i[x]` and `step_ie_i[x]` are both high, raw register (select 0) bit x reads 1. A done pulse with the enable bit low leaves bit x unchanged.
- R3: One cycle after a high `cmp_evt_i`, raw register bit 16 reads 1. It stays set until it is cleared.
- R4: A write to the mask register (select 1) loads bits 0-3 (per-sequencer pass enables) and bits 16-19 (comparator routing to line x). Every other bit reads 0. The mask holds its value when no such write occurs.
- R5: In the status register (select 2), bit x reads raw bit x AND mask bit x. Bit 16+x reads raw bit 16 AND mask bit 16+x.
- R6: `irq_o[x]` is the OR of status bits x and 16+x.
- R7: A write to the status register with bit x at 1 clears raw bit x. A write with any of bits 16-19 at 1 clears raw bit 16. Bits written 0 have no effect.
- R8: A raw flag sets while its mask bit is 0, and its interrupt line stays low.
- R9: If a set event and a clear write for the same flag fall in the same cycle, the flag ends up set.
- R10: Writes to the raw register have no effect. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_done_i | input | 4 | End-of-step pulse per sequencer |
| step_ie_i | input | 4 | Interrupt-enable bit of the finishing step |
| cmp_evt_i | input | 1 | Digital comparator interrupt event |
| reg_sel_i | input | 2 | Register select: 0 raw, 1 mask, 2 status, 3 none |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 4 | Interrupt line per sequencer |

## Verification
Directed patterns come first, and each one separates two behaviours:
- Done pulses with the enable bit low and high show whether the step enable qualifies the set.
- Mask values of zero and non-zero show the difference between polling and interrupting.
- Clear writes on the low bits and on the high bits show which flag each half clears.
- A set and a clear in the same cycle shows which one has priority.
- Writes of zeros, and writes to the raw register, show that stray accesses change nothing.

A long random mix of pulses, comparator events, mask writes and clear writes then checks every register and line against the reference model each cycle. This mix catches cross-coupling between sequencers and between the comparator routing bits.

// File: rtl/ais_pkg.sv
package ais_pkg;
  localparam int unsigned SEQ_N  = 4;
  localparam int unsigned DC_LSB = 16;
  localparam int unsigned REG_W  = 32;

  typedef enum logic [1:0] {
    REG_RAW  = 2'd0,
    REG_MASK = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ais_raw_flags.sv
module ais_raw_flags #(
  parameter int unsigned SEQ_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEQ_N-1:0] step_done_i,
  input  logic [SEQ_N-1:0] step_ie_i,
  input  logic             cmp_evt_i,
  input  logic [SEQ_N-1:0] seq_clr_i,
  input  logic             dc_clr_i,
  output logic [SEQ_N-1:0] seq_raw_o,
  output logic             dc_raw_o
);
  logic [SEQ_N-1:0] seq_set;
  assign seq_set = step_done_i & step_ie_i;

  // set has priority over clear
  for (genvar g = 0; g < SEQ_N; g++) begin : g_seq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          seq_raw_o[g] <= 1'b0;
      else if (seq_set[g])  seq_raw_o[g] <= 1'b1;
      else if (seq_clr_i[g]) seq_raw_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dc_raw_o <= 1'b0;
    else if (cmp_evt_i) dc_raw_o <= 1'b1;
    else if (dc_clr_i)  dc_raw_o <= 1'b0;
  end

  a_r2_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|seq_set) |=> ((seq_raw_o & $past(seq_set)) == $past(seq_set)));
  a_r7_clear_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(seq_clr_i & ~seq_set)) |=> ((seq_raw_o & $past(seq_clr_i & ~seq_set)) == '0));
  a_r3_dc_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_i |=> dc_raw_o);
  a_r7_dc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_clr_i && !cmp_evt_i) |=> !dc_raw_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_set == '0) |=> ((seq_raw_o & ~$past(seq_raw_o)) == '0));
endmodule

// File: rtl/ais_mask_reg.sv
module ais_mask_reg #(
  parameter int unsigned SEQ_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEQ_N-1:0] seq_mask_d_i,
  input  logic [SEQ_N-1:0] dc_en_d_i,
  output logic [SEQ_N-1:0] seq_mask_o,
  output logic [SEQ_N-1:0] dc_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_mask_o <= '0;
      dc_en_o    <= '0;
    end else if (we_i) begin
      seq_mask_o <= seq_mask_d_i;
      dc_en_o    <= dc_en_d_i;
    end
  end

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({seq_mask_o, dc_en_o}));
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ({seq_mask_o, dc_en_o} == $past({seq_mask_d_i, dc_en_d_i})));
endmodule

// File: rtl/ais_irq_route.sv
module ais_irq_route #(
  parameter int unsigned SEQ_N = 4
) (
  input  logic [SEQ_N-1:0] seq_raw_i,
  input  logic             dc_raw_i,
  input  logic [SEQ_N-1:0] seq_mask_i,
  input  logic [SEQ_N-1:0] dc_en_i,
  output logic [SEQ_N-1:0] seq_stat_o,
  output logic [SEQ_N-1:0] dc_stat_o,
  output logic [SEQ_N-1:0] irq_o
);
  assign seq_stat_o = seq_raw_i & seq_mask_i;
  assign dc_stat_o  = {SEQ_N{dc_raw_i}} & dc_en_i;
  assign irq_o      = seq_stat_o | dc_stat_o;
endmodule

// File: rtl/adc_irq_status.sv
module adc_irq_status
  import ais_pkg::*;
#(
  parameter int unsigned NSEQ   = ais_pkg::SEQ_N,
  parameter int unsigned DC_POS = ais_pkg::DC_LSB,
  parameter int unsigned DW     = ais_pkg::REG_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSEQ-1:0] step_done_i,
  input  logic [NSEQ-1:0] step_ie_i,
  input  logic            cmp_evt_i,
  input  logic [1:0]      reg_sel_i,
  input  logic            reg_wr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [NSEQ-1:0] irq_o
);
  reg_sel_e         sel;
  logic             wr_mask, wr_stat;
  logic [NSEQ-1:0]  seq_clr, seq_raw, seq_mask, dc_en, seq_stat, dc_stat;
  logic             dc_clr, dc_raw;
  logic             unused_wdata;

  assign sel          = reg_sel_e'(reg_sel_i);
  assign wr_mask      = reg_wr_i && (sel == REG_MASK);
  assign wr_stat      = reg_wr_i && (sel == REG_STAT);
  assign seq_clr      = wr_stat ? reg_wdata_i[NSEQ-1:0] : '0;
  assign dc_clr       = wr_stat && (|reg_wdata_i[DC_POS +: NSEQ]);
  assign unused_wdata = ^reg_wdata_i;

  ais_raw_flags #(.SEQ_N(NSEQ)) u_raw (
    .clk_i, .rst_ni, .step_done_i, .step_ie_i, .cmp_evt_i,
    .seq_clr_i(seq_clr), .dc_clr_i(dc_clr),
    .seq_raw_o(seq_raw), .dc_raw_o(dc_raw)
  );

  ais_mask_reg #(.SEQ_N(NSEQ)) u_mask (
    .clk_i, .rst_ni, .we_i(wr_mask),
    .seq_mask_d_i(reg_wdata_i[NSEQ-1:0]),
    .dc_en_d_i(reg_wdata_i[DC_POS +: NSEQ]),
    .seq_mask_o(seq_mask), .dc_en_o(dc_en)
  );

  ais_irq_route #(.SEQ_N(NSEQ)) u_route (
    .seq_raw_i(seq_raw), .dc_raw_i(dc_raw),
    .seq_mask_i(seq_mask), .dc_en_i(dc_en),
    .seq_stat_o(seq_stat), .dc_stat_o(dc_stat), .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      REG_RAW: begin
        reg_rdata_o[NSEQ-1:0] = seq_raw;
        reg_rdata_o[DC_POS]   = dc_raw;
      end
      REG_MASK: begin
        reg_rdata_o[NSEQ-1:0]       = seq_mask;
        reg_rdata_o[DC_POS +: NSEQ] = dc_en;
      end
      REG_STAT: begin
        reg_rdata_o[NSEQ-1:0]       = seq_stat;
        reg_rdata_o[DC_POS +: NSEQ] = dc_stat;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  a_r6_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_mask == '0 && dc_en == '0) |-> (irq_o == '0));
  a_r8_raw_not_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_en == '0) |-> ((irq_o & ~seq_raw) == '0));
  a_r10_raw_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && sel == REG_RAW && step_done_i == '0 && !cmp_evt_i)
      |=> ($stable(seq_raw) && $stable(dc_raw)));
endmodule

// File: tb/adc_irq_status_test.sv
`timescale 1ns/100ps
module adc_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  done_i = '0, ie_i = '0;
  logic        cmp_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  sel_i = '0;
  logic [31:0] wd_i = '0;
  logic [31:0] rd_o;
  logic [3:0]  irq_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit [3:0] m_raw = '0, m_mask = '0, m_dcon = '0;
  bit       m_dc = 1'b0;

  always #2 clk = ~clk;

  adc_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .step_done_i(done_i), .step_ie_i(ie_i),
    .cmp_evt_i(cmp_i), .reg_sel_i(sel_i), .reg_wr_i(wr_i), .reg_wdata_i(wd_i),
    .reg_rdata_o(rd_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_reg(input int s);
    logic [31:0] v = '0;
    case (s)
      0: begin v[3:0] = m_raw; v[16] = m_dc; end
      1: begin v[3:0] = m_mask; v[19:16] = m_dcon; end
      2: begin v[3:0] = m_raw & m_mask; v[19:16] = {4{m_dc}} & m_dcon; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic compare_all();
    logic [1:0] keep = sel_i;
    chk("R6 irq lines", {28'd0, irq_o}, {28'd0, (m_raw & m_mask) | ({4{m_dc}} & m_dcon)});
    for (int s = 0; s < 4; s++) begin
      sel_i = s[1:0];
      #0.2;
      case (s)
        0: chk("R2/R3 raw register", rd_o, exp_reg(0));
        1: chk("R4 mask register", rd_o, exp_reg(1));
        2: chk("R5 status register", rd_o, exp_reg(2));
        default: chk("R10 select 3 reads zero", rd_o, 32'd0);
      endcase
    end
    sel_i = keep;
  endtask

  task automatic cyc(input logic [3:0] dn, input logic [3:0] ie, input logic cm,
                     input logic wr, input logic [1:0] sel, input logic [31:0] wd);
    bit [3:0] clr;
    bit       dclr;
    done_i = dn; ie_i = ie; cmp_i = cm; wr_i = wr; sel_i = sel; wd_i = wd;
    @(posedge clk);
    clr  = (wr && sel == 2'd2) ? wd[3:0] : 4'd0;
    dclr = wr && sel == 2'd2 && (|wd[19:16]);
    m_raw = (dn & ie) | (m_raw & ~clr);
    m_dc  = cm | (m_dc & ~dclr);
    if (wr && sel == 2'd1) begin m_mask = wd[3:0]; m_dcon = wd[19:16]; end
    #1;
    done_i = '0; ie_i = '0; cmp_i = 1'b0; wr_i = 1'b0;
    compare_all();
    @(negedge clk);
  endtask

  task automatic idle(); cyc('0, '0, 1'b0, 1'b0, 2'd0, '0); endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    compare_all();  // R1 reset state, held in reset
    chk("R1 irq low in reset", {28'd0, irq_o}, 32'd0);
    #9; rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2: done without enable does nothing; with enable sets
    cyc(4'b1111, 4'b0000, 0, 0, 0, 0);
    sel_i = 2'd0; #0.2; chk("R2 unqualified done ignored", rd_o, 32'd0);
    cyc(4'b0101, 4'b0111, 0, 0, 0, 0);
    // R8: raw set with mask 0, no interrupt
    sel_i = 2'd0; #0.2; chk("R8 raw set while masked", rd_o, 32'h5);
    chk("R8 line low while masked", {28'd0, irq_o}, 32'd0);

    // R4: mask write, other bits drop
    cyc(0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF);
    sel_i = 2'd1; #0.2; chk("R4 mask readback", rd_o, 32'h000F_000F);
    cyc(0, 0, 0, 1, 2'd1, 32'h0002_0004);
    chk("R6 line 2 from own flag", {28'd0, irq_o}, 32'h4);

    // R3: comparator routed to line 1
    cyc(0, 0, 1, 0, 0, 0);
    sel_i = 2'd0; #0.2; chk("R3 comparator flag set", rd_o, 32'h0001_0005);
    chk("R6 comparator on line 1", {28'd0, irq_o}, 32'h6);
    idle();
    sel_i = 2'd0; #0.2; chk("R3 comparator flag sticky", rd_o, 32'h0001_0005);

    // R10: writes to raw register and zero writes to status do nothing
    cyc(0, 0, 0, 1, 2'd0, 32'h0000_0000);
    cyc(0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
    sel_i = 2'd0; #0.2; chk("R10 raw write inert", rd_o, 32'h0001_0005);
    cyc(0, 0, 0, 1, 2'd2, 32'h0000_0000);
    sel_i = 2'd0; #0.2; chk("R7 zero write inert", rd_o, 32'h0001_0005);

    // R7: clear bit 0 and comparator via bit 19 (not routed)
    cyc(0, 0, 0, 1, 2'd2, 32'h0008_0001);
    sel_i = 2'd0; #0.2; chk("R7 clear bit0 and comparator", rd_o, 32'h0000_0004);

    // R9: set and clear collide
    cyc(4'b0100, 4'b0100, 1, 1, 2'd2, 32'h0001_0004);
    sel_i = 2'd0; #0.2; chk("R9 set wins", rd_o, 32'h0001_0004);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] w = $urandom;
      cyc(r[3:0], r[7:4], (r[11:8] == 4'd0), (r[13:12] != 2'd0), r[15:14], w);
      if (r[19:16] == 4'd0) begin
        rst_n = 1'b0; m_raw = '0; m_mask = '0; m_dcon = '0; m_dc = 1'b0;
        #0.5; compare_all();  // R1 reset mid-run
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule